// File: doc/BRIEF.md
# Frequency-Change Watchdog with Revert

This block protects a clock generator while software changes its output frequency. Software first writes a nonzero timeout code and then changes the frequency code or an output divider ratio. That change starts the timer. If software does not write the timeout code back to zero before the time runs out, the block sets an alarm flag. It also forces the effective frequency selection back to a safe value and drives an active-low system reset pulse of fixed width.

The safe value comes from a revert control bit. With the bit low, the block returns to the strap code latched at power-up. With the bit high, it returns to the software code that was in force before the write that caused the hang. To make this possible, the block keeps a two-entry history of software frequency writes. Time is measured in ticks of an external millisecond strobe, so the time base can be scaled by a parameter. The reset output only drives low when the shared pin is configured as a reset output; otherwise the pin stays a stop input and the output holds high.

Top module: `wd_freq_guard`

## Requirements
- R1: After reset the alarm is 0, the reset output is 1, the software history holds code 0 in both entries, and the effective selection follows the strap code while software select is 0.
- R2: With no revert in force, the effective selection is the strap code when software select is 0 and the newest software code when software select is 1.
- R3: A write strobe on the software frequency code moves the newest entry into the older entry and stores the written code as the newest entry, one clock after the strobe.
- R4: A frequency-code write or a divider-ratio change strobe starts the timer only when the 4-bit timeout code is nonzero; with code 0 the strobe starts nothing.
- R5: Once started, the timer expires on the tick that completes code × TICKS_PER_SEC ticks counted after the starting cycle; a further change strobe while running restarts the count from zero.
- R6: Writing the timeout code to 0 while the timer runs stops it, with no alarm, no revert and no reset pulse.
- R7: On expiry the alarm goes to 1 in the next cycle and stays 1 until the timeout code reads 0, after which it is 0 one cycle later.
- R8: On expiry the effective selection becomes the strap code when the revert bit is 0, or the older software history entry when it is 1; this override holds until the next software frequency write.
- R9: Expiry starts a pulse that lasts PULSE_MS ticks. The reset output is low during the pulse only while pin_stop_mode is 0; with pin_stop_mode at 1 it stays high.
- R10: After the pulse the timer is idle; change strobes presented during the pulse are ignored, so no further pulse follows without a new start.
- R11: When a software write falls in the expiry cycle, the revert target is taken from the history as it was before that write, the override stays in force, and the history still shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle strobe marking each millisecond |
| wd_code | input | 4 | Timeout code, 0 = off, n = n seconds |
| revert_sel | input | 1 | Revert target: 0 = strap code, 1 = older software code |
| sw_fsel | input | 5 | Software frequency code |
| sw_fsel_wr | input | 1 | Write strobe for sw_fsel |
| sw_sel | input | 1 | 1 = software code drives the selection |
| ratio_chg | input | 1 | Strobe: an output divider ratio changed |
| strap_fsel | input | 5 | Strap code latched at power-up |
| pin_stop_mode | input | 1 | 1 = shared pin is a stop input, 0 = reset output |
| eff_fsel | output | 5 | Effective frequency selection |
| wd_alarm | output | 1 | Watchdog alarm flag |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The expiry and a software frequency write can fall in the same cycle. In that cycle the revert capture and the history shift compete for the same two registers. The bench counts the ticks after the start so that it can place the write exactly on the expiry tick. It then checks that the selection shows the entry that was older before the write, and that the override survives. A restart strobe and the expiry can also coincide; the cycle-by-cycle model follows the rule that expiry wins in both cases and compares all outputs on every clock.

// File: rtl/wd_guard_pkg.sv
package wd_guard_pkg;
   typedef enum logic [1:0] {
      WG_IDLE  = 2'd0,
      WG_RUN   = 2'd1,
      WG_PULSE = 2'd2
   } wg_state_e;
endpackage

// File: rtl/wd_span_cnt.sv
// Two-level time base: ticks within a second, then seconds against a limit.
module wd_span_cnt #(
   parameter int TICKS_PER_SEC = 1000,
   parameter int CODE_W        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              enable,
   input  logic              tick,
   input  logic [CODE_W-1:0] limit,
   output logic              hit
);
   localparam int MS_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

   logic              sec_step;
   logic [CODE_W-1:0] sec_q;
   logic [CODE_W:0]   sec_next;

   generate
      if (TICKS_PER_SEC == 1) begin : g_direct
         assign sec_step = enable & tick;
      end else begin : g_prescale
         logic [MS_W-1:0] ms_q;
         logic            ms_last;
         assign ms_last  = (ms_q == MS_W'(TICKS_PER_SEC - 1));
         assign sec_step = enable & tick & ms_last;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                ms_q <= '0;
            else if (restart)          ms_q <= '0;
            else if (enable && tick)   ms_q <= ms_last ? '0 : ms_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sec_q <= '0;
      else if (restart)   sec_q <= '0;
      else if (sec_step)  sec_q <= sec_q + 1'b1;
   end

   assign sec_next = {1'b0, sec_q} + {{CODE_W{1'b0}}, 1'b1};
   assign hit      = sec_step && (sec_next == {1'b0, limit});
endmodule

// File: rtl/wd_ctrl.sv
// Start / cancel / expire sequencing, alarm flag and reset pulse timing.
module wd_ctrl
   import wd_guard_pkg::*;
#(
   parameter int TICKS_PER_SEC = 1000,
   parameter int CODE_W        = 4,
   parameter int PULSE_MS      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              change,
   input  logic [CODE_W-1:0] code,
   output logic              expire,
   output logic              pulsing,
   output logic              alarm
);
   localparam int PC_W = (PULSE_MS > 1) ? $clog2(PULSE_MS) : 1;

   wg_state_e       state_q, state_d;
   logic [PC_W-1:0] pcnt_q;
   logic            code_zero, restart, hit, pulse_last;

   assign code_zero  = (code == '0);
   assign restart    = (state_q != WG_PULSE) && change && !code_zero;
   assign pulse_last = (pcnt_q == PC_W'(PULSE_MS - 1));

   wd_span_cnt #(
      .TICKS_PER_SEC(TICKS_PER_SEC),
      .CODE_W       (CODE_W)
   ) u_span (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .enable (state_q == WG_RUN),
      .tick   (tick),
      .limit  (code),
      .hit    (hit)
   );

   assign expire = (state_q == WG_RUN) && !code_zero && hit;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WG_IDLE:  if (restart) state_d = WG_RUN;
         WG_RUN: begin
            if (code_zero)   state_d = WG_IDLE;
            else if (expire) state_d = WG_PULSE;
         end
         WG_PULSE: if (tick && pulse_last) state_d = WG_IDLE;
         default:  state_d = WG_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WG_IDLE;
         pcnt_q  <= '0;
         alarm   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (expire)                             pcnt_q <= '0;
         else if (state_q == WG_PULSE && tick)   pcnt_q <= pcnt_q + 1'b1;
         if (code_zero)    alarm <= 1'b0;
         else if (expire)  alarm <= 1'b1;
      end
   end

   assign pulsing = (state_q == WG_PULSE);
endmodule

// File: rtl/wd_freq_hist.sv
// Two-entry software code history, revert capture and selection mux.
module wd_freq_hist #(
   parameter int FSEL_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr,
   input  logic [FSEL_W-1:0] sw_code,
   input  logic              sw_sel,
   input  logic [FSEL_W-1:0] strap,
   input  logic              revert_sel,
   input  logic              expire,
   output logic [FSEL_W-1:0] eff
);
   logic [FSEL_W-1:0] cur_q, prev_q, rev_code_q;
   logic              rev_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q      <= '0;
         prev_q     <= '0;
         rev_code_q <= '0;
         rev_act_q  <= 1'b0;
      end else begin
         if (sw_wr) begin
            prev_q <= cur_q;
            cur_q  <= sw_code;
         end
         if (expire) begin
            rev_act_q  <= 1'b1;
            rev_code_q <= revert_sel ? prev_q : strap;
         end else if (sw_wr) begin
            rev_act_q  <= 1'b0;
         end
      end
   end

   assign eff = rev_act_q ? rev_code_q : (sw_sel ? cur_q : strap);
endmodule

// File: rtl/wd_freq_guard.sv
module wd_freq_guard #(
   parameter int FSEL_W        = 5,
   parameter int CODE_W        = 4,
   parameter int TICKS_PER_SEC = 1000,
   parameter int PULSE_MS      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_ms,
   input  logic [CODE_W-1:0] wd_code,
   input  logic              revert_sel,
   input  logic [FSEL_W-1:0] sw_fsel,
   input  logic              sw_fsel_wr,
   input  logic              sw_sel,
   input  logic              ratio_chg,
   input  logic [FSEL_W-1:0] strap_fsel,
   input  logic              pin_stop_mode,
   output logic [FSEL_W-1:0] eff_fsel,
   output logic              wd_alarm,
   output logic              sys_rst_n
);
   generate
      if (FSEL_W < 1 || CODE_W < 1 || TICKS_PER_SEC < 1 || PULSE_MS < 1) begin : g_bad_param
         $error("wd_freq_guard: widths, tick rate and pulse length must be positive");
      end
   endgenerate

   logic expire, pulsing;

   wd_ctrl #(
      .TICKS_PER_SEC(TICKS_PER_SEC),
      .CODE_W       (CODE_W),
      .PULSE_MS     (PULSE_MS)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_ms),
      .change (sw_fsel_wr | ratio_chg),
      .code   (wd_code),
      .expire (expire),
      .pulsing(pulsing),
      .alarm  (wd_alarm)
   );

   wd_freq_hist #(
      .FSEL_W(FSEL_W)
   ) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_wr     (sw_fsel_wr),
      .sw_code   (sw_fsel),
      .sw_sel    (sw_sel),
      .strap     (strap_fsel),
      .revert_sel(revert_sel),
      .expire    (expire),
      .eff       (eff_fsel)
   );

   assign sys_rst_n = !(pulsing && !pin_stop_mode);
endmodule

// File: rtl/wd_freq_guard_chk.sv
module wd_freq_guard_chk #(
   parameter int FSEL_W = 5,
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] wd_code,
   input logic              revert_sel,
   input logic [FSEL_W-1:0] sw_fsel,
   input logic              sw_fsel_wr,
   input logic              sw_sel,
   input logic [FSEL_W-1:0] strap_fsel,
   input logic              pin_stop_mode,
   input logic [FSEL_W-1:0] eff_fsel,
   input logic              wd_alarm,
   input logic              sys_rst_n,
   input logic              expire
);
   // R7
   alarm_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> wd_alarm);

   // R7
   alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_code == '0) |=> !wd_alarm);

   // R9
   stop_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_stop_mode |-> sys_rst_n);

   // R9
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (!sys_rst_n || pin_stop_mode));

   // R8
   revert_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !revert_sel) |=> (eff_fsel == $past(strap_fsel)));

   // R3
   sw_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_fsel_wr && sw_sel && !expire) |=> (!sw_sel || eff_fsel == $past(sw_fsel)));
endmodule

bind wd_freq_guard wd_freq_guard_chk #(
   .FSEL_W(FSEL_W),
   .CODE_W(CODE_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wd_code      (wd_code),
   .revert_sel   (revert_sel),
   .sw_fsel      (sw_fsel),
   .sw_fsel_wr   (sw_fsel_wr),
   .sw_sel       (sw_sel),
   .strap_fsel   (strap_fsel),
   .pin_stop_mode(pin_stop_mode),
   .eff_fsel     (eff_fsel),
   .wd_alarm     (wd_alarm),
   .sys_rst_n    (sys_rst_n),
   .expire       (expire)
);

// File: tb/tb_wd_freq_guard.sv
`timescale 1ns/1ps
module tb_wd_freq_guard;
   localparam int TPS = 3;
   localparam int PMS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_ms = 1'b0;
   logic [3:0] wd_code = 4'd0;
   logic       revert_sel = 1'b1;
   logic [4:0] sw_fsel = 5'd0;
   logic       sw_fsel_wr = 1'b0;
   logic       sw_sel = 1'b0;
   logic       ratio_chg = 1'b0;
   logic [4:0] strap_fsel = 5'h07;
   logic       pin_stop_mode = 1'b0;
   logic [4:0] eff_fsel;
   logic       wd_alarm;
   logic       sys_rst_n;

   int n_tests = 0;
   int n_fail  = 0;
   int low_seen = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   wd_freq_guard #(
      .FSEL_W(5), .CODE_W(4), .TICKS_PER_SEC(TPS), .PULSE_MS(PMS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wd_code(wd_code),
      .revert_sel(revert_sel), .sw_fsel(sw_fsel), .sw_fsel_wr(sw_fsel_wr),
      .sw_sel(sw_sel), .ratio_chg(ratio_chg), .strap_fsel(strap_fsel),
      .pin_stop_mode(pin_stop_mode), .eff_fsel(eff_fsel), .wd_alarm(wd_alarm),
      .sys_rst_n(sys_rst_n)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model: st 0 idle, 1 running, 2 pulsing
   int m_cur = 0, m_prev = 0, m_rev_act = 0, m_rev_code = 0, m_alarm = 0;
   int m_st = 0, m_ms = 0, m_sec = 0, m_pcnt = 0;

   always @(posedge clk) begin
      int code_v, expire_v, change_v, eff_exp, rst_exp;
      if (!rst_n) begin
         m_cur = 0; m_prev = 0; m_rev_act = 0; m_rev_code = 0; m_alarm = 0;
         m_st = 0; m_ms = 0; m_sec = 0; m_pcnt = 0;
      end else begin
         code_v   = int'(wd_code);
         change_v = int'(sw_fsel_wr | ratio_chg);
         expire_v = (m_st == 1 && code_v != 0 && tick_ms && m_ms == TPS-1 && m_sec+1 == code_v) ? 1 : 0;
         if (m_st == 1 && code_v == 0) m_st = 0;
         else if (expire_v != 0) begin
            m_st = 2; m_pcnt = 0;
         end else if (m_st != 2 && change_v != 0 && code_v != 0) begin
            m_st = 1; m_ms = 0; m_sec = 0;
         end else if (m_st == 1 && tick_ms) begin
            if (m_ms == TPS-1) begin m_ms = 0; m_sec++; end
            else m_ms++;
         end else if (m_st == 2 && tick_ms) begin
            if (m_pcnt == PMS-1) m_st = 0;
            else m_pcnt++;
         end
         if (code_v == 0) m_alarm = 0;
         else if (expire_v != 0) m_alarm = 1;
         if (expire_v != 0) begin
            m_rev_act = 1;
            m_rev_code = revert_sel ? m_prev : int'(strap_fsel);
         end else if (sw_fsel_wr) m_rev_act = 0;
         if (sw_fsel_wr) begin m_prev = m_cur; m_cur = int'(sw_fsel); end
      end
      #1;
      if (rst_n) begin
         eff_exp = m_rev_act ? m_rev_code : (sw_sel ? m_cur : int'(strap_fsel));
         rst_exp = (m_st == 2 && !pin_stop_mode) ? 0 : 1;
         chk("R2/R8 eff_fsel model", int'(eff_fsel), eff_exp);
         chk("R7 alarm model", int'(wd_alarm), m_alarm);
         chk("R9 sys_rst_n model", int'(sys_rst_n), rst_exp);
         if (!sys_rst_n) low_seen++;
      end
   end

   task automatic drive(input logic wr, input logic [4:0] f, input logic rc);
      @(negedge clk);
      tick_ms    = !tick_ms;
      sw_fsel_wr = wr;
      if (wr) sw_fsel = f;
      ratio_chg  = rc;
   endtask

   task automatic smp;
      @(posedge clk);
      #1.5;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 5'd0, 1'b0);
   endtask

   task automatic wait_alarm(input int max, output int cycles);
      cycles = 0;
      for (int i = 0; i < max; i++) begin
         drive(1'b0, 5'd0, 1'b0);
         smp();
         cycles++;
         if (wd_alarm) break;
      end
   endtask

   initial begin
      int cyc, lows, base, cnt;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      smp();
      chk("R1 eff after reset", int'(eff_fsel), 5'h07);
      chk("R1 alarm after reset", int'(wd_alarm), 0);
      chk("R1 reset out after reset", int'(sys_rst_n), 1);

      sw_sel = 1'b1;
      smp();
      chk("R1 history cleared", int'(eff_fsel), 0);
      drive(1'b1, 5'h0A, 1'b0);
      smp();
      chk("R2 R3 software code selected", int'(eff_fsel), 5'h0A);
      base = low_seen;
      idle(40);
      smp();
      chk("R4 no start with code 0 alarm", int'(wd_alarm), 0);
      chk("R4 no start with code 0 reset", low_seen - base, 0);

      // arm with code 2, revert to previous software code
      wd_code = 4'd2; revert_sel = 1'b1;
      drive(1'b1, 5'h11, 1'b0);
      wait_alarm(60, cyc);
      chk("R5 expiry after 2*TPS ticks", (cyc >= 11 && cyc <= 12) ? 1 : 0, 1);
      chk("R7 alarm set", int'(wd_alarm), 1);
      chk("R9 reset low during pulse", int'(sys_rst_n), 0);
      chk("R8 revert to previous code", int'(eff_fsel), 5'h0A);
      lows = 1;
      drive(1'b0, 5'd0, 1'b1);   // change during pulse: ignored (R10)
      smp();
      while (!sys_rst_n && lows < 40) begin
         lows++;
         drive(1'b0, 5'd0, 1'b0);
         smp();
      end
      chk("R9 pulse width in cycles", lows, 2*PMS);
      base = low_seen;
      idle(40);
      smp();
      chk("R10 no second pulse", low_seen - base, 0);
      chk("R7 alarm held", int'(wd_alarm), 1);
      wd_code = 4'd0;
      drive(1'b0, 5'd0, 1'b0);
      smp();
      chk("R7 alarm cleared by code 0", int'(wd_alarm), 0);

      // cancel
      wd_code = 4'd3;
      drive(1'b1, 5'h12, 1'b0);
      idle(10);
      base = low_seen;
      wd_code = 4'd0;
      idle(60);
      smp();
      chk("R6 cancel no alarm", int'(wd_alarm), 0);
      chk("R6 cancel no reset", low_seen - base, 0);
      chk("R6 cancel no revert", int'(eff_fsel), 5'h12);

      // revert to strap
      revert_sel = 1'b0; wd_code = 4'd1;
      drive(1'b1, 5'h13, 1'b0);
      wait_alarm(30, cyc);
      chk("R8 revert to strap", int'(eff_fsel), 5'h07);
      idle(20);
      wd_code = 4'd0;
      idle(2);

      // ratio change starts timer
      revert_sel = 1'b1; wd_code = 4'd1;
      drive(1'b0, 5'd0, 1'b1);
      wait_alarm(30, cyc);
      chk("R4 ratio change starts timer", int'(wd_alarm), 1);
      chk("R8 revert to older entry", int'(eff_fsel), 5'h12);
      idle(20);
      wd_code = 4'd0;
      drive(1'b1, 5'h14, 1'b0);
      smp();
      chk("R8 write ends override", int'(eff_fsel), 5'h14);

      // stop mode: no reset drive
      pin_stop_mode = 1'b1; wd_code = 4'd1;
      base = low_seen;
      drive(1'b0, 5'd0, 1'b1);
      wait_alarm(30, cyc);
      idle(20);
      smp();
      chk("R9 stop mode alarm", int'(wd_alarm), 1);
      chk("R9 stop mode reset high", low_seen - base, 0);
      wd_code = 4'd0;
      pin_stop_mode = 1'b0;
      idle(2);

      // restart
      wd_code = 4'd1;
      drive(1'b0, 5'd0, 1'b1);
      idle(3);
      drive(1'b0, 5'd0, 1'b1);
      wait_alarm(30, cyc);
      chk("R5 restart resets count", (cyc >= 5 && cyc <= 6) ? 1 : 0, 1);
      idle(20);
      wd_code = 4'd0;
      idle(2);

      // collision: software write on the expiry tick (history 14 newest, 13 older)
      wd_code = 4'd1; revert_sel = 1'b1;
      drive(1'b0, 5'd0, 1'b1);
      cnt = 0;
      for (int i = 0; i < 40; i++) begin
         if (!tick_ms && cnt == TPS-1) begin
            drive(1'b1, 5'h15, 1'b0);
            break;
         end
         drive(1'b0, 5'd0, 1'b0);
         if (tick_ms) cnt++;
      end
      smp();
      chk("R11 alarm on collision", int'(wd_alarm), 1);
      chk("R11 target from pre-write history", int'(eff_fsel), 5'h13);
      idle(20);
      wd_code = 4'd0;
      drive(1'b1, 5'h16, 1'b0);
      smp();
      chk("R11 history shifted", int'(eff_fsel), 5'h16);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule